// File: doc/BRIEF.md
# DC-Balance Lane Word Encoder

This block encodes one lane of a parallel-to-serial link transmitter. On each accepted clock it takes a 6-bit data word and produces a 7-bit symbol. The symbol holds the word, either as it is or with every bit inverted, together with a flag bit that records which choice was made. The block keeps a saturating running disparity and picks the polarity that pulls the line back toward zero DC bias.

The receiving end restores the word by XOR-ing the data bits with the flag. A small combinational decoder module, `dcb_lane_decoder`, is included for that purpose and for use by the bench. The serializer, the line drivers and any edge boosting lie outside this block.

Top module: `dcb_lane_encoder`

## Requirements
- R1: `sym_o` is laid out as {flag, payload}. The flag is bit 6 and the payload is bits 5:0. The flag is 0 when the payload equals the input word and 1 when it is the bitwise inverse of the word.
- R2: A word taken with `valid_i` high appears on `sym_o` one clock later, with `valid_o` high. `valid_o` is low one clock after `valid_i` is low.
- R3: The word disparity is the count of 1 bits minus the count of 0 bits in the 6-bit word. Its range is -6 to +6.
- R4: While the running disparity is positive, the word is inverted if its disparity is positive and sent as is otherwise.
- R5: While the running disparity is negative, the word is sent as is if its disparity is positive and inverted otherwise.
- R6: While the running disparity is exactly zero, the word is always inverted (flag 1).
- R7: After each accepted word, the running disparity changes by one of two amounts. It gains (word disparity - 1) when the word is sent as is, and gains (1 - word disparity) when the word is inverted.
- R8: The running disparity is clamped to the range -6 to +7. Two cases show the limits:
  - From 0, an all-zero word takes it to +7.
  - From +1, an all-zero word takes it to -6.
- R9: While `rst_ni` is low, the running disparity is 0, `valid_o` is 0 and `sym_o` is 0.
- R10: A cycle with `valid_i` low leaves `sym_o` and the running disparity unchanged, whatever `data_i` carries.
- R11: The decoder output equals `sym_o[5:0]` XOR (`sym_o[6]` replicated six times). This gives back the original word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word qualifier |
| data_i | input | 6 | Lane data word |
| valid_o | output | 1 | Symbol qualifier, one cycle after `valid_i` |
| sym_o | output | 7 | Encoded symbol {flag, payload} |

## Verification
A fixed opening sequence drives the running disparity to exactly +7, to exactly -6 and back through zero. This separates the clamp limits and the forced inversion at zero from the ordinary sign-based choice.

Next, every ordered pair of the 64 words is sent back to back. The first word of each pair sets up a running disparity and the second tests the polarity choice from there. Across the sweep, every reachable running disparity meets every word disparity.

A pseudo-random stream with gaps in `valid_i` and junk on `data_i` during the gaps then shows that idle cycles neither move the disparity nor disturb the held symbol.

The bench's own arithmetic model predicts every symbol, and the decoder round trip is compared on each one.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int unsigned LANE_W = 6;
  localparam int          RD_HI  = 7;
  localparam int          RD_LO  = -6;
  localparam int unsigned RD_W   = 4;
endpackage

// File: rtl/dcb_word_disp.sv
// Signed disparity (ones minus zeros) of one lane word.
module dcb_word_disp #(
  parameter int unsigned DATA_W = 6,
  parameter int unsigned DISP_W = 5
) (
  input  logic [DATA_W-1:0]        data_i,
  output logic signed [DISP_W-1:0] disp_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < int'(DATA_W); i++) ones = ones + CNT_W'(data_i[i]);
  end

  logic [DISP_W-1:0] ones_x;
  assign ones_x = DISP_W'(ones);
  // 2*ones - DATA_W, modular arithmetic yields two's complement
  assign disp_o = signed'((ones_x << 1) - DISP_W'(DATA_W));
endmodule

// File: rtl/dcb_pol_select.sv
// Polarity choice from the running and word disparities.
module dcb_pol_select #(
  parameter int unsigned RD_W   = 4,
  parameter int unsigned DISP_W = 5
) (
  input  logic signed [RD_W-1:0]   rd_i,
  input  logic signed [DISP_W-1:0] disp_i,
  output logic                     inv_o
);
  always_comb begin
    if (rd_i == '0)      inv_o = 1'b1;
    else if (rd_i > 0)   inv_o = (disp_i > 0);
    else                 inv_o = (disp_i <= 0);
  end
endmodule

// File: rtl/dcb_rd_track.sv
// Saturating running disparity register.
module dcb_rd_track #(
  parameter int          RD_HI  = 7,
  parameter int          RD_LO  = -6,
  parameter int unsigned RD_W   = 4,
  parameter int unsigned DISP_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic                     inv_i,
  input  logic signed [DISP_W-1:0] disp_i,
  output logic signed [RD_W-1:0]   rd_o
);
  localparam int unsigned SUM_W = ((RD_W > DISP_W) ? RD_W : DISP_W) + 2;
  localparam logic signed [SUM_W-1:0] HI_X = SUM_W'(RD_HI);
  localparam logic signed [SUM_W-1:0] LO_X = SUM_W'(RD_LO);
  localparam logic signed [SUM_W-1:0] ONE_X = SUM_W'(1);

  logic signed [SUM_W-1:0] disp_x, rd_x, delta, sum, clamped;
  logic signed [RD_W-1:0]  rd_q;

  assign disp_x = {{(SUM_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign rd_x   = {{(SUM_W-RD_W){rd_q[RD_W-1]}}, rd_q};

  // flag bit itself counts +1 when set, -1 when clear
  assign delta = inv_i ? (ONE_X - disp_x) : (disp_x - ONE_X);
  assign sum   = rd_x + delta;

  always_comb begin
    if (sum > HI_X)      clamped = HI_X;
    else if (sum < LO_X) clamped = LO_X;
    else                 clamped = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_q <= '0;
    else if (upd_i) rd_q <= clamped[RD_W-1:0];
  end

  assign rd_o = rd_q;

  // R8
  rd_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q <= RD_HI) && (rd_q >= RD_LO));

  // R10
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(rd_q));
endmodule

// File: rtl/dcb_lane_decoder.sv
// Receive-side inverse: payload XOR replicated flag.
module dcb_lane_decoder #(
  parameter int unsigned DATA_W = 6
) (
  input  logic [DATA_W:0]   sym_i,
  output logic [DATA_W-1:0] data_o
);
  assign data_o = sym_i[DATA_W-1:0] ^ {DATA_W{sym_i[DATA_W]}};
endmodule

// File: rtl/dcb_lane_encoder.sv
module dcb_lane_encoder #(
  parameter int unsigned DATA_W = dcb_pkg::LANE_W,
  parameter int          RD_HI  = dcb_pkg::RD_HI,
  parameter int          RD_LO  = dcb_pkg::RD_LO,
  parameter int unsigned RD_W   = dcb_pkg::RD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W:0]   sym_o
);
  localparam int unsigned DISP_W = $clog2(DATA_W + 1) + 2;

  logic signed [DISP_W-1:0] disp_w;
  logic signed [RD_W-1:0]   rd_w;
  logic                     inv_w;
  logic [DATA_W:0]          sym_q;
  logic                     vld_q;

  dcb_word_disp #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_disp (
    .data_i (data_i),
    .disp_o (disp_w)
  );

  dcb_pol_select #(.RD_W(RD_W), .DISP_W(DISP_W)) u_pol (
    .rd_i   (rd_w),
    .disp_i (disp_w),
    .inv_o  (inv_w)
  );

  dcb_rd_track #(.RD_HI(RD_HI), .RD_LO(RD_LO), .RD_W(RD_W), .DISP_W(DISP_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (valid_i),
    .inv_i  (inv_w),
    .disp_i (disp_w),
    .rd_o   (rd_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) sym_q <= {inv_w, data_i ^ {DATA_W{inv_w}}};
    end
  end

  assign sym_o   = sym_q;
  assign valid_o = vld_q;

  // R2
  vld_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R6
  zero_rd_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rd_w == '0) |=> sym_o[DATA_W]);

  // R1
  round_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((sym_o[DATA_W-1:0] ^ {DATA_W{sym_o[DATA_W]}}) == $past(data_i)));

  // R4
  pos_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rd_w > 0) |=> (sym_o[DATA_W] == ($past(disp_w) > 0)));

  // R10
  sym_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sym_o));
endmodule

// File: tb/dcb_lane_encoder_test.sv
`timescale 1ns/1ps
module dcb_lane_encoder_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [5:0] data_i = '0;
  logic       valid_o;
  logic [6:0] sym_o;
  logic [5:0] dec_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_rd  = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dcb_lane_encoder uut (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i),
    .data_i (data_i), .valid_o (valid_o), .sym_o (sym_o)
  );

  dcb_lane_decoder #(.DATA_W(6)) u_dec (.sym_i (sym_o), .data_o (dec_o));

  function automatic int wdisp(logic [5:0] w);
    int c = 0;
    for (int i = 0; i < 6; i++) c += int'(w[i]);
    return 2 * c - 6;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One accepted word; model predicts symbol and new running disparity.
  task automatic send(logic [5:0] w, string tag, int lit = -1);
    int  d = wdisp(w);
    bit  inv;
    int  nrd;
    logic [6:0] exp;
    string req;
    if (m_rd == 0)      begin inv = 1'b1;    req = "R6"; end
    else if (m_rd > 0)  begin inv = (d > 0);  req = "R4"; end
    else                begin inv = (d <= 0); req = "R5"; end
    exp = {inv, inv ? ~w : w};
    nrd = m_rd + (inv ? (1 - d) : (d - 1));   // R7, word disparity per R3
    if (nrd > 7) nrd = 7;                      // R8
    if (nrd < -6) nrd = -6;
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = w;
    @(negedge clk_i);
    check({req, " R3 R7 R1 sym ", tag}, 32'(sym_o), 32'(exp));
    check({"R2 valid ", tag}, 32'(valid_o), 32'd1);
    check({"R11 decode ", tag}, 32'(dec_o), 32'(w));
    if (lit >= 0) check({"literal ", tag}, 32'(sym_o), 32'(lit));
    m_rd = nrd;
    valid_i = 1'b0;
  endtask

  // R10: idle with junk data, symbol must hold
  task automatic idle(logic [5:0] junk);
    logic [6:0] prev;
    @(negedge clk_i);
    prev    = sym_o;
    valid_i = 1'b0;
    data_i  = junk;
    @(negedge clk_i);
    check("R10 hold", 32'(sym_o), 32'(prev));
    check("R2 idle valid", 32'(valid_o), 32'd0);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk_i);
    // R9
    check("R9 reset valid", 32'(valid_o), 32'd0);
    check("R9 reset sym", 32'(sym_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    send(6'b000000, "R8 to +7", 7'b1111111);
    send(6'b000000, "R7 +7 to 0", 7'b0000000);
    send(6'b111111, "R6 to -5", 7'b1000000);
    idle(6'b101101);
    send(6'b111111, "R5 -5 to 0", 7'b0111111);
    send(6'b010101, "R6 zero word", 7'b1101010);
    send(6'b000000, "R8 to -6", 7'b0000000);
    send(6'b000000, "R5 -6 to +1", 7'b1111111);

    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        send(6'(a), "pair a");
        send(6'(b), "pair b");
        if (((a * 64 + b) % 97) == 0) idle(6'(b ^ 6'h2A));
      end
    end

    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:14] == 2'b00) idle(lfsr[5:0]);
      else send(lfsr[5:0], "random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule